// File: doc/BRIEF.md
# UART FIFO Trigger and Status Unit

This unit sits between the serial shifters of a UART and the register bus. It holds two byte FIFOs: one filled by the receiver and drained by register reads, and one filled by register writes and drained by the transmitter. Each FIFO has a programmable threshold. Crossing a threshold raises a live output and a sticky status flag. The receive FIFO also stores a parity tag and a framing tag with every byte. From these tags the unit keeps running counts of the errored bytes currently held, and it reports the tags of the byte at the head of the FIFO.

Software clears a status flag by writing zero to it. A clear only takes effect once software has seen the flag as one. A flag whose cause is still present comes back one cycle after it is cleared. Control bits empty either FIFO, and two further control bits are passed straight out to drive loopback and modem-control logic elsewhere in the UART. The register selector picks one of six views: control, counts, status, line status, transmit data and receive data.

Top module: `uqf_ctl`

## Requirements
- R1: The receive threshold code is control bits 7:6, and it selects 1, 4, 8 or 14 characters for codes 00, 01, 10 and 11. `rx_level_hit` is high while the receive count is at or above the threshold, and the sticky receive-full flag (status bit 1) sets on the edge after that condition holds.
- R2: The transmit threshold code is control bits 5:4, and it selects 8, 4, 2 or 1 characters for codes 00, 01, 10 and 11. `tx_level_hit` is high while the transmit count is at or below the threshold, and the sticky transmit-empty flag (status bit 5) sets on the edge after that condition holds.
- R3: The control register (select 0) reads back the value last written to bits 7:0. Bit 0 drives `loopback_en` and bit 3 drives `modem_ctl_en`.
- R4: The count register (select 1) shows the receive occupancy in bits 4:0 and the transmit occupancy in bits 12:8.
- R5: Both FIFOs are first-in first-out. A register read of select 5 returns the receive head and pops it. A register write to select 4 pushes onto the transmit FIFO. `tx_data` and `tx_valid` show the transmit head, and `tx_pop` removes it.
- R6: The status register (select 2) has bit 3 and bit 2, which show the framing tag and the parity tag of the receive head byte (0 when the FIFO is empty). Writes do not change these two bits.
- R7: Status bits 15:12 hold the number of parity-tagged bytes held in the receive FIFO, and bits 11:8 hold the number of framing-tagged bytes. Each count saturates at 15.
- R8: Status bits 7, 6, 5, 4, 1 and 0 (mask 0xF3) and line status bit 0 are sticky. Writing 0 to such a bit clears it only if the bit was read as 1 through its register since it last set. Writing 1 leaves it unchanged.
- R9: A sticky flag whose set condition still holds after a clear reads 0 in the cycle after the clearing write, and reads 1 again one cycle later.
- R10: A receive push while the receive FIFO holds 16 bytes is dropped, and it sets line status bit 0 (select 3). The bytes already held are unchanged.
- R11: Control bit 1 empties the receive FIFO and zeroes both error counts. Control bit 2 empties the transmit FIFO. While either bit is set, pushes to that FIFO are ignored.
- R12: Status bit 7 sets on an accepted push that carries either error tag. Bit 6 sets while the transmit FIFO is empty and `tx_idle` is high. Bit 4 sets on `rx_brk`. Bit 0 sets on `rx_idle` while the receive FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select: 0 control, 1 counts, 2 status, 3 line status, 4 tx data, 5 rx data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms sticky clears, pops the receive FIFO) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the current select |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_data | input | DW | Received byte |
| rx_perr | input | 1 | Parity tag of the received byte |
| rx_ferr | input | 1 | Framing tag of the received byte |
| rx_brk | input | 1 | Break seen on the line |
| rx_idle | input | 1 | Receive line has gone quiet |
| tx_data | output | DW | Transmit FIFO head |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_idle | input | 1 | Transmit shifter has finished |
| rx_level_hit | output | 1 | Receive count at or above threshold |
| tx_level_hit | output | 1 | Transmit count at or below threshold |
| loopback_en | output | 1 | Loopback select |
| modem_ctl_en | output | 1 | Modem-control enable |

## Verification
The bench walks every code of both threshold encodings, with occupancies on each side of the threshold. A design that reused one mapping for both directions, or used strict instead of inclusive comparison, would give the wrong hit value on at least one of these rows. The bench writes zero to a flag that has not yet been read and expects the flag to survive, and it checks that a flag with a standing cause reads 0 for exactly one cycle after a clear. It fills the receive FIFO to 16 parity-tagged bytes and then pushes once more. A wrong design would wrap the 4-bit error field to zero, accept the seventeenth byte, or overwrite the oldest byte.

// File: rtl/uqf_pkg.sv
package uqf_pkg;
   // register selector values
   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_COUNT = 3'd1;
   localparam logic [2:0] SEL_STAT  = 3'd2;
   localparam logic [2:0] SEL_LINE  = 3'd3;
   localparam logic [2:0] SEL_TXD   = 3'd4;
   localparam logic [2:0] SEL_RXD   = 3'd5;

   // sticky (write-zero clearable) status bits
   localparam logic [7:0] STICKY_MASK = 8'hF3;

   // receive threshold: grows with code
   function automatic int unsigned rx_thresh(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

   // transmit threshold: shrinks with code
   function automatic int unsigned tx_thresh(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 4;
         2'd2:    return 2;
         default: return 1;
      endcase
   endfunction
endpackage

// File: rtl/uqf_fifo.sv
module uqf_fifo #(
   parameter int DW    = 8,
   parameter int TW    = 2,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1,
   localparam int TWX  = (TW > 0) ? TW : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           push,
   input  logic [DW-1:0]  din,
   input  logic [TWX-1:0] tin,
   input  logic           pop,
   output logic [DW-1:0]  dout,
   output logic [TWX-1:0] tout,
   output logic [CW-1:0]  count,
   output logic           full,
   output logic           empty
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uqf_fifo: DEPTH must be a power of two >= 2");
   end

   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic [DW-1:0] dmem [DEPTH];
   logic          push_ok, pop_ok;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push & ~full & ~flush;
   assign pop_ok  = pop & ~empty & ~flush;
   assign count   = cnt;
   assign dout    = dmem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + AW'(1);
         if (pop_ok)  rp <= rp + AW'(1);
         cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) dmem[wp] <= din;
   end

   if (TW > 0) begin : g_tags
      logic [TWX-1:0] tmem [DEPTH];
      always_ff @(posedge clk) begin
         if (push_ok) tmem[wp] <= tin;
      end
      assign tout = tmem[rp];
   end else begin : g_no_tags
      logic unused_tin;
      assign unused_tin = ^tin;
      assign tout       = '0;
   end
endmodule

// File: rtl/uqf_trig.sv
module uqf_trig
   import uqf_pkg::*;
#(
   parameter int CW = 5
) (
   input  logic [1:0]    rx_code,
   input  logic [1:0]    tx_code,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_cnt,
   output logic          rx_hit,
   output logic          tx_hit
);
   assign rx_hit = (rx_cnt >= CW'(rx_thresh(rx_code)));
   assign tx_hit = (tx_cnt <= CW'(tx_thresh(tx_code)));
endmodule

// File: rtl/uqf_flag.sv
module uqf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic seen_i,
   input  logic clr_req_i,
   output logic q_o
);
   logic armed, clr;

   assign clr = clr_req_i & armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o   <= 1'b0;
         armed <= 1'b0;
      end else begin
         q_o   <= clr ? 1'b0 : (q_o | set_i);
         armed <= clr ? 1'b0 : (armed | (seen_i & q_o));
      end
   end
endmodule

// File: rtl/uqf_ctl.sv
module uqf_ctl
   import uqf_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    reg_sel,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [15:0]   reg_wdata,
   output logic [15:0]   reg_rdata,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_perr,
   input  logic          rx_ferr,
   input  logic          rx_brk,
   input  logic          rx_idle,
   output logic [DW-1:0] tx_data,
   output logic          tx_valid,
   input  logic          tx_pop,
   input  logic          tx_idle,
   output logic          rx_level_hit,
   output logic          tx_level_hit,
   output logic          loopback_en,
   output logic          modem_ctl_en
);
   if (DEPTH < 16 || CW > 8) begin : g_bad_depth
      $error("uqf_ctl: DEPTH must lie in 16..128");
   end
   if (DW < 1 || DW > 16) begin : g_bad_dw
      $error("uqf_ctl: DW must lie in 1..16");
   end

   logic [7:0]    ctrl_q;
   logic          rx_flush, tx_flush;
   logic [CW-1:0] rx_cnt, tx_cnt;
   logic          rx_full, rx_empty, tx_empty;
   logic [DW-1:0] rx_head;
   logic [1:0]    rx_head_tag;   // {parity, framing}
   logic          rx_pop, tx_push;
   logic          rx_push_ok, rx_pop_ok;
   logic          rx_hit, tx_hit;
   logic [CW-1:0] pe_cnt, fe_cnt;
   logic [3:0]    pe_fld, fe_fld;
   logic [7:0]    src, sticky;
   logic          stat_rd, stat_wr, line_rd, line_wr;
   logic          ovr_q;

   assign rx_flush = ctrl_q[1];
   assign tx_flush = ctrl_q[2];
   assign rx_pop   = reg_rd & (reg_sel == SEL_RXD);
   assign tx_push  = reg_wr & (reg_sel == SEL_TXD);
   assign stat_rd  = reg_rd & (reg_sel == SEL_STAT);
   assign stat_wr  = reg_wr & (reg_sel == SEL_STAT);
   assign line_rd  = reg_rd & (reg_sel == SEL_LINE);
   assign line_wr  = reg_wr & (reg_sel == SEL_LINE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ctrl_q <= '0;
      else if (reg_wr && (reg_sel == SEL_CTRL))     ctrl_q <= reg_wdata[7:0];
   end

   uqf_fifo #(.DW(DW), .TW(2), .DEPTH(DEPTH)) rx_fifo_i (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_push), .din(rx_data), .tin({rx_perr, rx_ferr}),
      .pop(rx_pop), .dout(rx_head), .tout(rx_head_tag),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   logic unused_tx_tag, unused_tx_full;
   uqf_fifo #(.DW(DW), .TW(0), .DEPTH(DEPTH)) tx_fifo_i (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(tx_push), .din(reg_wdata[DW-1:0]), .tin(1'b0),
      .pop(tx_pop), .dout(tx_data), .tout(unused_tx_tag),
      .count(tx_cnt), .full(unused_tx_full), .empty(tx_empty)
   );

   uqf_trig #(.CW(CW)) trig_i (
      .rx_code(ctrl_q[7:6]), .tx_code(ctrl_q[5:4]),
      .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
      .rx_hit(rx_hit), .tx_hit(tx_hit)
   );

   // error counts over the receive FIFO contents
   assign rx_push_ok = rx_push & ~rx_full & ~rx_flush;
   assign rx_pop_ok  = rx_pop & ~rx_empty & ~rx_flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pe_cnt <= '0;
         fe_cnt <= '0;
      end else if (rx_flush) begin
         pe_cnt <= '0;
         fe_cnt <= '0;
      end else begin
         pe_cnt <= pe_cnt + CW'(rx_push_ok & rx_perr) - CW'(rx_pop_ok & rx_head_tag[1]);
         fe_cnt <= fe_cnt + CW'(rx_push_ok & rx_ferr) - CW'(rx_pop_ok & rx_head_tag[0]);
      end
   end

   assign pe_fld = (pe_cnt > CW'(15)) ? 4'hF : pe_cnt[3:0];
   assign fe_fld = (fe_cnt > CW'(15)) ? 4'hF : fe_cnt[3:0];

   // per-bit source: set condition for sticky bits, live value otherwise
   assign src[7] = rx_push_ok & (rx_perr | rx_ferr);
   assign src[6] = tx_empty & tx_idle;
   assign src[5] = tx_hit;
   assign src[4] = rx_brk;
   assign src[3] = ~rx_empty & rx_head_tag[0];
   assign src[2] = ~rx_empty & rx_head_tag[1];
   assign src[1] = rx_hit;
   assign src[0] = rx_idle & ~rx_empty;

   for (genvar i = 0; i < 8; i++) begin : g_stat
      if (STICKY_MASK[i]) begin : g_sticky
         uqf_flag flag_i (
            .clk(clk), .rst_n(rst_n), .set_i(src[i]),
            .seen_i(stat_rd), .clr_req_i(stat_wr & ~reg_wdata[i]),
            .q_o(sticky[i])
         );
      end else begin : g_live
         assign sticky[i] = src[i];
      end
   end

   uqf_flag ovr_i (
      .clk(clk), .rst_n(rst_n),
      .set_i(rx_push & rx_full & ~rx_flush),
      .seen_i(line_rd), .clr_req_i(line_wr & ~reg_wdata[0]),
      .q_o(ovr_q)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_CTRL:  reg_rdata[7:0] = ctrl_q;
         SEL_COUNT: begin
            reg_rdata[CW-1:0] = rx_cnt;
            reg_rdata[8 +: CW] = tx_cnt;
         end
         SEL_STAT:  reg_rdata = {pe_fld, fe_fld, sticky};
         SEL_LINE:  reg_rdata[0] = ovr_q;
         SEL_RXD:   reg_rdata[DW-1:0] = rx_head;
         default:   reg_rdata = '0;
      endcase
   end

   assign tx_valid     = ~tx_empty;
   assign rx_level_hit = rx_hit;
   assign tx_level_hit = tx_hit;
   assign loopback_en  = ctrl_q[0];
   assign modem_ctl_en = ctrl_q[3];
endmodule

// File: rtl/uqf_ctl_chk.sv
module uqf_ctl_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    ctrl_q,
   input logic [CW-1:0] rx_cnt,
   input logic [CW-1:0] tx_cnt,
   input logic [7:0]    sticky,
   input logic          ovr_q,
   input logic          rx_push,
   input logic          reg_wr,
   input logic [2:0]    reg_sel,
   input logic [15:0]   reg_wdata
);
   function automatic logic [CW-1:0] rx_lvl(input logic [1:0] c);
      return (c == 2'd0) ? CW'(1) : (c == 2'd1) ? CW'(4) : (c == 2'd2) ? CW'(8) : CW'(14);
   endfunction
   function automatic logic [CW-1:0] tx_lvl(input logic [1:0] c);
      return (c == 2'd0) ? CW'(8) : (c == 2'd1) ? CW'(4) : (c == 2'd2) ? CW'(2) : CW'(1);
   endfunction

   logic st_wr, ln_wr;
   assign st_wr = reg_wr && (reg_sel == 3'd2);
   assign ln_wr = reg_wr && (reg_sel == 3'd3);

   AST_RDF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt >= rx_lvl(ctrl_q[7:6])) && !(st_wr && !reg_wdata[1]) |=> sticky[1]); // R1
   AST_TDFE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= tx_lvl(ctrl_q[5:4])) && !(st_wr && !reg_wdata[5]) |=> sticky[5]); // R2
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH))); // R5
   AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[1] |=> (rx_cnt == $past(rx_cnt)) || (rx_cnt == $past(rx_cnt) + CW'(1))
                     || (rx_cnt + CW'(1) == $past(rx_cnt))); // R5
   AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      sticky[7] && !(st_wr && !reg_wdata[7]) |=> sticky[7]); // R8
   AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && (rx_cnt == CW'(DEPTH)) && !ctrl_q[1] && !(ln_wr && !reg_wdata[0]) |=> ovr_q); // R10
   AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[1] |=> (rx_cnt == '0)); // R11
endmodule

bind uqf_ctl uqf_ctl_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
   .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
   .sticky(sticky), .ovr_q(ovr_q), .rx_push(rx_push), .reg_wr(reg_wr),
   .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/uqf_ctl_tb_top.sv
module uqf_ctl_tb_top;
   localparam int CLK_P = 10;
   localparam logic [2:0] S_CTRL = 3'd0, S_CNT = 3'd1, S_STAT = 3'd2,
                          S_LINE = 3'd3, S_TXD = 3'd4, S_RXD = 3'd5;

   // rx code, rx fill, tx code, tx fill, expected rx hit, expected tx hit
   localparam int TBL [8][6] = '{
      '{0, 1, 0, 8, 1, 1},
      '{1, 3, 1, 5, 0, 0},
      '{1, 4, 2, 2, 1, 1},
      '{2, 7, 3, 2, 0, 0},
      '{2, 8, 3, 1, 1, 1},
      '{3, 13, 2, 3, 0, 0},
      '{3, 14, 0, 9, 1, 0},
      '{0, 0, 0, 0, 0, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        rx_push = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_brk = 1'b0, rx_idle = 1'b0;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_pop = 1'b0, tx_idle = 1'b0;
   logic        rx_level_hit, tx_level_hit, loopback_en, modem_ctl_en;

   int n_chk = 0, n_bad = 0;
   logic [15:0] d;

   always #(CLK_P/2) clk = ~clk;

   uqf_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_idle(rx_idle),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop), .tx_idle(tx_idle),
      .rx_level_hit(rx_level_hit), .tx_level_hit(tx_level_hit),
      .loopback_en(loopback_en), .modem_ctl_en(modem_ctl_en)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] v);
      @(negedge clk); reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
      @(posedge clk); @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [15:0] v);
      @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 v = reg_rdata;
      @(posedge clk); @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [2:0] s, output logic [15:0] v);
      reg_sel = s; #1 v = reg_rdata;
   endtask

   task automatic rxp(input logic [7:0] b, input logic pe, input logic fe);
      @(negedge clk); rx_data = b; rx_perr = pe; rx_ferr = fe; rx_push = 1'b1;
      @(posedge clk); @(negedge clk); rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
   endtask

   task automatic pulse_txpop();
      @(negedge clk); tx_pop = 1'b1; @(posedge clk); @(negedge clk); tx_pop = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      // reset state
      repeat (3) @(negedge clk);
      peek(S_STAT, d); chk("R6 status in reset", d, 16'h0000);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      peek(S_CTRL, d);  chk("R3 ctrl after reset", d, 16'h0000);
      peek(S_CNT, d);   chk("R4 counts after reset", d, 16'h0000);
      peek(S_STAT, d);  chk("R2 only TDFE after reset", d, 16'h0020);
      peek(S_LINE, d);  chk("R10 line after reset", d, 16'h0000);
      chk("R3 loopback after reset", {15'd0, loopback_en}, 16'd0);

      // threshold table: R1 R2 R4
      for (int e = 0; e < 8; e++) begin
         logic [7:0] cv;
         cv = 8'((TBL[e][0] << 6) | (TBL[e][2] << 4));
         wr(S_CTRL, {8'h00, cv | 8'h06});
         wr(S_CTRL, {8'h00, cv});
         for (int k = 0; k < TBL[e][1]; k++) rxp(8'(k), 1'b0, 1'b0);
         for (int k = 0; k < TBL[e][3]; k++) wr(S_TXD, 16'(k + 8'h40));
         chk("R1 rx threshold", {15'd0, rx_level_hit}, 16'(TBL[e][4]));
         chk("R2 tx threshold", {15'd0, tx_level_hit}, 16'(TBL[e][5]));
         peek(S_CNT, d);
         chk("R4 count layout", d, 16'((TBL[e][3] << 8) | TBL[e][1]));
      end

      // R3 control outputs
      wr(S_CTRL, 16'h0009);
      chk("R3 loopback", {15'd0, loopback_en}, 16'd1);
      chk("R3 modem ctl", {15'd0, modem_ctl_en}, 16'd1);
      peek(S_CTRL, d); chk("R3 ctrl readback", d, 16'h0009);
      wr(S_CTRL, 16'h0000);

      // R5 ordering
      rxp(8'hA1, 0, 0); rxp(8'hB2, 0, 0); rxp(8'hC3, 0, 0);
      peek(S_CNT, d); chk("R5 rx count 3", d, 16'h0003);
      rd(S_RXD, d); chk("R5 rx first", d, 16'h00A1);
      rd(S_RXD, d); chk("R5 rx second", d, 16'h00B2);
      rd(S_RXD, d); chk("R5 rx third", d, 16'h00C3);
      wr(S_TXD, 16'h0011); wr(S_TXD, 16'h0022);
      chk("R5 tx valid", {15'd0, tx_valid}, 16'd1);
      chk("R5 tx head", {8'd0, tx_data}, 16'h0011);
      pulse_txpop();
      chk("R5 tx next", {8'd0, tx_data}, 16'h0022);
      pulse_txpop();
      chk("R5 tx drained", {15'd0, tx_valid}, 16'd0);

      // R12 TEND and DR
      tx_idle = 1'b1; @(posedge clk); @(negedge clk); tx_idle = 1'b0;
      peek(S_STAT, d); chk("R12 TEND set", {15'd0, d[6]}, 16'd1);
      rxp(8'h55, 0, 0);
      rx_idle = 1'b1; @(posedge clk); @(negedge clk); rx_idle = 1'b0;
      peek(S_STAT, d); chk("R12 DR set", {15'd0, d[0]}, 16'd1);
      rd(S_RXD, d); chk("R5 rx single", d, 16'h0055);

      // R6 R7 error tags
      wr(S_CTRL, 16'h0002); wr(S_CTRL, 16'h0000);
      rxp(8'h01, 1, 0); rxp(8'h02, 0, 1); rxp(8'h03, 1, 1); rxp(8'h04, 0, 0);
      peek(S_STAT, d);
      chk("R7 parity count", {12'd0, d[15:12]}, 16'd2);
      chk("R7 framing count", {12'd0, d[11:8]}, 16'd2);
      chk("R6 head parity", {14'd0, d[3:2]}, 16'b01);
      chk("R12 ER set", {15'd0, d[7]}, 16'd1);
      rd(S_RXD, d); chk("R5 tagged head", d, 16'h0001);
      peek(S_STAT, d);
      chk("R7 counts after pop", {8'd0, d[15:8]}, 16'h0012);
      chk("R6 head framing", {14'd0, d[3:2]}, 16'b10);
      rd(S_STAT, d);
      wr(S_STAT, 16'h0000);
      peek(S_STAT, d);
      chk("R8 ER cleared", {15'd0, d[7]}, 16'd0);
      chk("R6 FER not clearable", {15'd0, d[3]}, 16'd1);

      // R7 saturation, R10 overrun
      wr(S_CTRL, 16'h0002); wr(S_CTRL, 16'h0000);
      for (int k = 0; k < 16; k++) rxp(8'(k), 1, 0);
      peek(S_STAT, d); chk("R7 parity saturates", {12'd0, d[15:12]}, 16'd15);
      rxp(8'hEE, 0, 0);
      peek(S_LINE, d); chk("R10 overrun set", d, 16'h0001);
      peek(S_CNT, d);  chk("R10 count stays full", d, 16'h0010);
      rd(S_RXD, d);    chk("R10 oldest kept", d, 16'h0000);

      // R11 flush
      wr(S_TXD, 16'h0099);
      wr(S_CTRL, 16'h0006);
      @(posedge clk); @(negedge clk);
      peek(S_CNT, d);  chk("R11 both emptied", d, 16'h0000);
      peek(S_STAT, d); chk("R11 error counts zero", {8'd0, d[15:8]}, 16'h0000);
      rxp(8'h77, 0, 0);
      peek(S_CNT, d);  chk("R11 push ignored in flush", d, 16'h0000);
      wr(S_CTRL, 16'h0000);

      // R8 overrun clear after read
      rd(S_LINE, d); chk("R10 overrun held", d, 16'h0001);
      wr(S_LINE, 16'h0000);
      peek(S_LINE, d); chk("R8 overrun cleared", d, 16'h0000);

      // R8 arming rule on BRK
      @(negedge clk); rx_brk = 1'b1; @(posedge clk); @(negedge clk); rx_brk = 1'b0;
      wr(S_STAT, 16'hFFEF);
      peek(S_STAT, d); chk("R8 unread BRK survives zero write", {15'd0, d[4]}, 16'd1);
      rd(S_STAT, d);
      wr(S_STAT, 16'hFFFF);
      peek(S_STAT, d); chk("R8 write one keeps BRK", {15'd0, d[4]}, 16'd1);
      wr(S_STAT, 16'hFFEF);
      peek(S_STAT, d); chk("R8 armed BRK cleared", {15'd0, d[4]}, 16'd0);

      // R9 standing condition re-sets TDFE
      rd(S_STAT, d); chk("R2 TDFE standing", {15'd0, d[5]}, 16'd1);
      wr(S_STAT, 16'hFFDF);
      peek(S_STAT, d); chk("R9 TDFE low after clear", {15'd0, d[5]}, 16'd0);
      @(posedge clk); @(negedge clk);
      peek(S_STAT, d); chk("R9 TDFE back", {15'd0, d[5]}, 16'd1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule